// File: doc/BRIEF.md
# Single-Bit Test-and-Modify Unit

This unit performs one of four single-bit operations on an operand: it can report a bit, invert it, force it to zero or force it to one. The caller hands over an instruction word, the operand, a bit-number source (either a full register value or an immediate byte) and a flag that says whether the target is a data register or a memory byte. The unit returns the new operand, a write-back enable, the zero flag that describes the chosen bit before it was touched, and the number of machine cycles the operation is charged.

All inputs are captured on a start strobe. One clock later the unit raises a single-cycle done pulse, and its outputs then stay fixed until the next strobe. A data-register target is 32 bits wide and the bit number wraps at 32. A memory target is one byte and the bit number wraps at 8. The unit forms no addresses and drives no bus. Its caller fetches the operand, supplies the register value picked by the register-select output, and stores the result when write-back is enabled.

Top module: `bitop_unit`

## Requirements
- R1: Instruction word bits [7:6] choose the operation: 0 = test, 1 = change (invert), 2 = clear, 3 = set.
- R2: When `imm_form_i` is 1, the bit number is `imm_i` and `regsrc_i` is ignored. When it is 0, the bit number is `regsrc_i` and `imm_i` is ignored. `bitreg_sel_o` always shows instruction word bits [11:9] with no clock delay.
- R3: With `mem_target_i` = 0, only bits [4:0] of the bit number are used. With `mem_target_i` = 1, only bits [2:0] are used, only operand bits [7:0] take part, and result bits [31:8] are 0.
- R4: `z_o` is 1 when the selected bit of the original operand is 0, and 0 when that bit is 1.
- R5: Change XORs the one-bit mask into the operand, clear ANDs the operand with the inverted mask, and set ORs the mask in. `wr_en_o` is 1 for these three operations. Test returns the operand unchanged with `wr_en_o` = 0.
- R6: No result bit other than the selected bit differs from the (width-reduced) operand.
- R7: In the register-sourced form, `cycles_o` is 8 for change and set. Test is 4 and clear is 8, and each of these two is increased by 2 for a data-register target.
- R8: In the immediate form, `cycles_o` is 12 for change and set. Test is 8 and clear is 12, and each of these two is increased by 2 for a data-register target.
- R9: A register-sourced request whose target mode field (instruction word bits [5:3]) equals 3'b001 sets `illegal_o`. In that case `wr_en_o` = 0, `cycles_o` = 0, the result equals the width-reduced operand and `z_o` keeps its previous value. The immediate form with the same mode field is not flagged.
- R10: `done_o` is high for exactly the one cycle after each cycle in which `start_i` is high.
- R11: After reset all outputs except `bitreg_sel_o` are 0. `result_o`, `z_o`, `wr_en_o`, `cycles_o` and `illegal_o` change only in the cycle after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture the inputs and begin an operation |
| opword_i | input | 16 | Instruction word: [11:9] register select, [7:6] operation, [5:3] target mode |
| operand_i | input | 32 | Operand read from the target |
| regsrc_i | input | 32 | Bit number taken from a register |
| imm_i | input | 8 | Bit number taken from an immediate byte |
| imm_form_i | input | 1 | 1 selects the immediate bit number |
| mem_target_i | input | 1 | 1 when the target is a memory byte |
| bitreg_sel_o | output | 3 | Register index for the bit-number source |
| done_o | output | 1 | One-cycle pulse when results are valid |
| result_o | output | 32 | Modified operand |
| wr_en_o | output | 1 | Result must be written back |
| z_o | output | 1 | Zero flag of the selected original bit |
| cycles_o | output | 5 | Cycle count charged to the operation |
| illegal_o | output | 1 | Request is not a bit operation |

## Verification
The bench drives bit numbers above the wrap limit in both target widths. A design that wrapped at the wrong width would then pick the wrong bit, and a memory request would leak operand bits above the byte. It checks that Z is taken from the bit before modification, so a design that sampled the result would show an inverted flag on change, clear and set. It covers all six cycle-count cases, where a missed register surcharge or immediate surcharge shows up as a count off by 2 or 4. It also checks the register-sourced mode 3'b001 request: a design that still wrote back, or that disturbed Z, is caught there.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   typedef enum logic [1:0] {
      BOP_TEST = 2'd0,
      BOP_FLIP = 2'd1,
      BOP_CLR  = 2'd2,
      BOP_SET  = 2'd3
   } bop_e;

   localparam logic [2:0] MODE_ADDR_DIRECT = 3'b001;
endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int SRC_W      = 32,
   parameter int IMM_W      = 8,
   parameter int MASK_STYLE = 0
) (
   input  logic [SRC_W-1:0]  regsrc,
   input  logic [IMM_W-1:0]  imm,
   input  logic              imm_form,
   input  logic              mem_target,
   output logic [DATA_W-1:0] mask
);
   localparam int IDX_W  = $clog2(DATA_W);
   localparam int BIDX_W = $clog2(BYTE_W);

   generate
      if (DATA_W != (1 << IDX_W)) begin : g_bad_data_w
         $error("DATA_W must be a power of two");
      end
      if (BYTE_W != (1 << BIDX_W) || BYTE_W > DATA_W) begin : g_bad_byte_w
         $error("BYTE_W must be a power of two no wider than DATA_W");
      end
      if (IMM_W < IDX_W || SRC_W < IDX_W) begin : g_bad_src_w
         $error("bit-number sources too narrow for DATA_W");
      end
   endgenerate

   logic [IDX_W-1:0] raw_idx;
   logic [IDX_W-1:0] idx;

   always_comb begin
      raw_idx = imm_form ? imm[IDX_W-1:0] : regsrc[IDX_W-1:0];
      if (mem_target) idx = {{(IDX_W-BIDX_W){1'b0}}, raw_idx[BIDX_W-1:0]};
      else            idx = raw_idx;
   end

   generate
      if (MASK_STYLE == 0) begin : g_shift_mask
         always_comb mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
      end else begin : g_decode_mask
         for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign mask[b] = (idx == IDX_W'(b));
         end
      end
   endgenerate

   // R3: exactly one mask bit, and none above the byte on a memory target
   always_comb begin
      assert_onehot_mask_R3 : assert ($onehot(mask));
      if (mem_target)
         assert_byte_mask_R3 : assert ((mask >> BYTE_W) == '0);
   end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] mask,
   input  logic              mem_target,
   input  bop_e              op,
   output logic [DATA_W-1:0] opnd_eff,
   output logic [DATA_W-1:0] result,
   output logic              zero
);
   always_comb begin
      if (mem_target) opnd_eff = {{(DATA_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]};
      else            opnd_eff = operand;
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_lane
         always_comb begin
            unique case (op)
               BOP_FLIP: result[b] = opnd_eff[b] ^ mask[b];
               BOP_CLR:  result[b] = opnd_eff[b] & ~mask[b];
               BOP_SET:  result[b] = opnd_eff[b] | mask[b];
               default:  result[b] = opnd_eff[b];
            endcase
         end
      end
   endgenerate

   assign zero = ~|(opnd_eff & mask);

   // R6: only the masked lane may change
   always_comb begin
      assert_single_bit_R6 : assert (((result ^ opnd_eff) & ~mask) == '0);
   end
endmodule

// File: rtl/bitop_timing.sv
module bitop_timing
   import bitop_pkg::*;
#(
   parameter int CYC_W        = 5,
   parameter int TEST_BASE    = 4,
   parameter int MODIFY_BASE  = 8,
   parameter int IMM_EXTRA    = 4,
   parameter int WIDE_EXTRA   = 2
) (
   input  bop_e             op,
   input  logic             imm_form,
   input  logic             mem_target,
   input  logic             illegal,
   output logic [CYC_W-1:0] cycles
);
   localparam int MAX_CYC = MODIFY_BASE + IMM_EXTRA + WIDE_EXTRA;

   generate
      if (MAX_CYC >= (1 << CYC_W)) begin : g_bad_cyc_w
         $error("CYC_W too narrow for the largest cycle count");
      end
   endgenerate

   logic [CYC_W-1:0] base;
   logic             wide_pen;

   always_comb begin
      base     = (op == BOP_TEST) ? CYC_W'(TEST_BASE) : CYC_W'(MODIFY_BASE);
      wide_pen = !mem_target && (op == BOP_TEST || op == BOP_CLR);
      if (illegal) cycles = '0;
      else cycles = base
                  + (imm_form ? CYC_W'(IMM_EXTRA) : '0)
                  + (wide_pen ? CYC_W'(WIDE_EXTRA) : '0);
   end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int BYTE_W      = 8,
   parameter int OPW_W       = 16,
   parameter int IMM_W       = 8,
   parameter int CYC_W       = 5,
   parameter int MASK_STYLE  = 0,
   parameter int TEST_BASE   = 4,
   parameter int MODIFY_BASE = 8,
   parameter int IMM_EXTRA   = 4,
   parameter int WIDE_EXTRA  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OPW_W-1:0]  opword_i,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [DATA_W-1:0] regsrc_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              imm_form_i,
   input  logic              mem_target_i,
   output logic [2:0]        bitreg_sel_o,
   output logic              done_o,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              z_o,
   output logic [CYC_W-1:0]  cycles_o,
   output logic              illegal_o
);
   generate
      if (OPW_W < 12) begin : g_bad_opw
         $error("instruction word must hold bits [11:0]");
      end
   endgenerate

   bop_e              op_c;
   logic              illegal_c;
   logic [DATA_W-1:0] mask_c, opnd_c, res_c;
   logic              zero_c;
   logic [CYC_W-1:0]  cyc_c;
   bop_e              op_q;
   logic              mem_q;

   assign bitreg_sel_o = opword_i[11:9];
   assign op_c         = bop_e'(opword_i[7:6]);
   assign illegal_c    = !imm_form_i && (opword_i[5:3] == MODE_ADDR_DIRECT);

   bitop_index #(
      .DATA_W(DATA_W), .BYTE_W(BYTE_W), .SRC_W(DATA_W), .IMM_W(IMM_W),
      .MASK_STYLE(MASK_STYLE)
   ) u_index (
      .regsrc(regsrc_i), .imm(imm_i), .imm_form(imm_form_i),
      .mem_target(mem_target_i), .mask(mask_c)
   );

   bitop_alu #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_alu (
      .operand(operand_i), .mask(mask_c), .mem_target(mem_target_i),
      .op(op_c), .opnd_eff(opnd_c), .result(res_c), .zero(zero_c)
   );

   bitop_timing #(
      .CYC_W(CYC_W), .TEST_BASE(TEST_BASE), .MODIFY_BASE(MODIFY_BASE),
      .IMM_EXTRA(IMM_EXTRA), .WIDE_EXTRA(WIDE_EXTRA)
   ) u_timing (
      .op(op_c), .imm_form(imm_form_i), .mem_target(mem_target_i),
      .illegal(illegal_c), .cycles(cyc_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         result_o  <= '0;
         wr_en_o   <= 1'b0;
         z_o       <= 1'b0;
         cycles_o  <= '0;
         illegal_o <= 1'b0;
         op_q      <= BOP_TEST;
         mem_q     <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            op_q      <= op_c;
            mem_q     <= mem_target_i;
            illegal_o <= illegal_c;
            cycles_o  <= cyc_c;
            result_o  <= illegal_c ? opnd_c : res_c;
            wr_en_o   <= !illegal_c && (op_c != BOP_TEST);
            if (!illegal_c) z_o <= zero_c;
         end
      end
   end

   assert_done_follows_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   assert_done_single_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);
   assert_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(result_o) && $stable(z_o) && $stable(wr_en_o)
                   && $stable(cycles_o) && $stable(illegal_o));
   assert_test_no_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == BOP_TEST) |-> !wr_en_o);
   assert_illegal_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !wr_en_o && cycles_o == '0);
   assert_byte_result_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_q |-> (result_o >> BYTE_W) == '0);
   assert_cycle_range_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !illegal_o) |-> cycles_o >= CYC_W'(TEST_BASE) && !cycles_o[0]);
endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   typedef struct packed {
      logic [15:0] opw;
      logic [31:0] opnd;
      logic [31:0] rsrc;
      logic [7:0]  imm;
      logic        immf;
      logic        mem;
      logic [31:0] eres;
      logic        ewe;
      logic        ez;
      logic [4:0]  ecyc;
   } vec_t;

   // op in [7:6]: 0 test 1 change 2 clear 3 set; mode in [5:3]
   localparam vec_t VECS [NV] = '{
      '{16'h0100, 32'h0000_0010, 32'd4,          8'h00, 1'b0, 1'b0, 32'h0000_0010, 1'b0, 1'b0, 5'd6 },
      '{16'h0140, 32'h8000_0000, 32'd35,         8'h00, 1'b0, 1'b0, 32'h8000_0008, 1'b1, 1'b1, 5'd8 },
      '{16'h0180, 32'hFFFF_FFFF, 32'd31,         8'h05, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0, 5'd10},
      '{16'h01C0, 32'h0000_0000, 32'd0,          8'h07, 1'b0, 1'b0, 32'h0000_0001, 1'b1, 1'b1, 5'd8 },
      '{16'h01D0, 32'hABCD_EF00, 32'd13,         8'h00, 1'b0, 1'b1, 32'h0000_0020, 1'b1, 1'b1, 5'd8 },
      '{16'h0810, 32'h0000_0080, 32'd0,          8'hFF, 1'b1, 1'b1, 32'h0000_0080, 1'b0, 1'b0, 5'd8 },
      '{16'h0850, 32'h0000_00FF, 32'd0,          8'h0A, 1'b1, 1'b1, 32'h0000_00FB, 1'b1, 1'b0, 5'd12},
      '{16'h0880, 32'h0000_1000, 32'd0,          8'h2C, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 5'd14},
      '{16'h0800, 32'h0000_0000, 32'd0,          8'h1F, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 5'd10},
      '{16'h08D0, 32'h0000_0001, 32'd9,          8'h00, 1'b1, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 5'd12},
      '{16'h0190, 32'h1234_5655, 32'hFFFF_FFF8,  8'h03, 1'b0, 1'b1, 32'h0000_0054, 1'b1, 1'b0, 5'd8 }
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] opword_i = '0;
   logic [31:0] operand_i = '0;
   logic [31:0] regsrc_i = '0;
   logic [7:0]  imm_i = '0;
   logic        imm_form_i = 1'b0;
   logic        mem_target_i = 1'b0;
   logic [2:0]  bitreg_sel_o;
   logic        done_o, wr_en_o, z_o, illegal_o;
   logic [31:0] result_o;
   logic [4:0]  cycles_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitop_unit u_bitop_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opword_i(opword_i),
      .operand_i(operand_i), .regsrc_i(regsrc_i), .imm_i(imm_i),
      .imm_form_i(imm_form_i), .mem_target_i(mem_target_i),
      .bitreg_sel_o(bitreg_sel_o), .done_o(done_o), .result_o(result_o),
      .wr_en_o(wr_en_o), .z_o(z_o), .cycles_o(cycles_o), .illegal_o(illegal_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [15:0] opw, input logic [31:0] opnd,
                        input logic [31:0] rsrc, input logic [7:0] imm,
                        input logic immf, input logic mem);
      @(negedge clk);
      opword_i = opw; operand_i = opnd; regsrc_i = rsrc; imm_i = imm;
      imm_form_i = immf; mem_target_i = mem; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 reset done", 32'(done_o), 0);
      chk("R11 reset result", result_o, 0);
      chk("R11 reset we/z/ill", {29'd0, wr_en_o, z_o, illegal_o}, 0);
      chk("R11 reset cycles", 32'(cycles_o), 0);
      rst_n = 1'b1;

      // R2: register select is combinational from [11:9]
      @(negedge clk);
      opword_i = 16'h0A00;
      #1 chk("R2 bitreg_sel", 32'(bitreg_sel_o), 5);

      // Table: R1 R3 R4 R5 R7 R8
      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].opw, VECS[i].opnd, VECS[i].rsrc, VECS[i].imm,
               VECS[i].immf, VECS[i].mem);
         chk($sformatf("R10 done v%0d", i), 32'(done_o), 1);
         chk($sformatf("R1/R5 result v%0d", i), result_o, VECS[i].eres);
         chk($sformatf("R5 wr_en v%0d", i), 32'(wr_en_o), 32'(VECS[i].ewe));
         chk($sformatf("R4 z v%0d", i), 32'(z_o), 32'(VECS[i].ez));
         chk($sformatf("R7/R8 cycles v%0d", i), 32'(cycles_o), 32'(VECS[i].ecyc));
         chk($sformatf("R9 not illegal v%0d", i), 32'(illegal_o), 0);
      end

      // R11 + R10: outputs hold while inputs wander, done drops
      @(negedge clk);
      opword_i = 16'h01C0; operand_i = 32'hFFFF_0000; regsrc_i = 32'd1;
      repeat (3) @(negedge clk);
      chk("R10 done single pulse", 32'(done_o), 0);
      chk("R11 result held", result_o, 32'h0000_0054);
      chk("R11 cycles held", 32'(cycles_o), 8);

      // R9: register-sourced mode 001 is flagged; z keeps 0 from last vector
      issue(16'h01C8, 32'h0000_0000, 32'd2, 8'h00, 1'b0, 1'b0);
      chk("R9 illegal flag", 32'(illegal_o), 1);
      chk("R9 no write", 32'(wr_en_o), 0);
      chk("R9 cycles zero", 32'(cycles_o), 0);
      chk("R9 result passthrough", result_o, 0);
      chk("R9 z unchanged", 32'(z_o), 0);

      // R9: immediate form with mode 001 is a normal set
      issue(16'h08C8, 32'h0000_0000, 32'd0, 8'h03, 1'b1, 1'b0);
      chk("R9 imm not flagged", 32'(illegal_o), 0);
      chk("R5 imm set result", result_o, 32'h0000_0008);
      chk("R4 imm set z", 32'(z_o), 1);
      chk("R8 imm set cycles", 32'(cycles_o), 12);

      // R6/R3: memory clear ignores upper operand bits and regsrc upper bits
      issue(16'h0190, 32'hFFFF_FFFF, 32'h0000_0107, 8'h00, 1'b0, 1'b1);
      chk("R3 mem clear bit7", result_o, 32'h0000_007F);
      chk("R6 mem z", 32'(z_o), 0);

      // R10: back-to-back starts keep done high
      @(negedge clk);
      opword_i = 16'h0140; operand_i = 0; regsrc_i = 1; imm_form_i = 0;
      mem_target_i = 0; start_i = 1'b1;
      @(negedge clk);
      operand_i = 32'h2; regsrc_i = 1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R10 back-to-back done", 32'(done_o), 1);
      chk("R5 second change", result_o, 32'h0);
      chk("R4 second z", 32'(z_o), 0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule